// File: doc/BRIEF.md
# Power-Good Strap Capture Sequencer

This block brings a clock generator up from power-on reset. It captures the frequency-select straps once, at the moment an active-low power-good strobe first becomes trustworthy. The straps are a binary select pin, a three-level select pin that arrives already decoded to a 2-bit code, and a current-multiplier pin. The block starts the VCO, counts a fixed settling delay, and only then latches the straps and enables the clock outputs. From that point the strobe and the strap pins have no further effect until the next power-on reset.

All sequencing advances on a free-running reference-clock tick, which acts as a clock enable on the fast core clock. The strobe is asynchronous. It is synchronized first and must then be observed low on two successive ticks. The sequence state code is exported so the surrounding logic can gate its own outputs.

Top module: `pgseq_top`

## Requirements
- R1: While `rst_n` is low, and until two clock edges after its release, `seq_state` is 0, `vco_en` and `out_en` are 0, and all latched strap outputs are 0.
- R2: The first tick after reset release moves `seq_state` from 0 (off) to 1 (waiting for the strobe).
- R3: While the synchronized strobe is high, the block stays in state 1 and the latched strap outputs do not change, whatever the strap pins carry.
- R4: The block leaves state 1 for state 2 (settling) only on a tick where the strobe, after a two-flop synchronizer, is low and was also low at the previous tick. A low seen by only one tick does not advance the state.
- R5: State 2 lasts exactly `DELAY_TICKS` ticks. The tick that completes the count moves the block to state 3 (running).
- R6: On the tick that enters state 3, the strap pins are latched. The S2 code is 00 = low, 01 = mid, 10 = high, and the illegal code 11 is latched as 01 (mid).
- R7: Once in state 3, the block stays there and the latched straps hold their value regardless of the strobe and strap pins, until reset.
- R8: The state and the delay count change only on clocks where `ref_tick` is high.
- R9: `vco_en` is 1 in states 1, 2 and 3. `out_en` is 1 only in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ref_tick | input | 1 | One-clock pulse per reference-clock period |
| pg_n | input | 1 | Power-good strobe, active low, asynchronous |
| strap_s1 | input | 1 | Binary frequency-select strap |
| strap_s2 | input | 2 | Pre-decoded three-level strap code |
| strap_mult | input | 1 | Current-multiplier strap |
| lat_s1 | output | 1 | Latched S1 |
| lat_s2 | output | 2 | Latched, legalized S2 code |
| lat_mult | output | 1 | Latched multiplier strap |
| vco_en | output | 1 | VCO enable |
| out_en | output | 1 | Clock outputs enable |
| seq_state | output | 2 | Sequence state 0..3 |

## Verification
Outputs are registered. A tick seen at a clock edge shows its effect on `seq_state` and the latches straight after that edge. A strobe change needs two further edges through the synchronizer before a tick can see it, and then a second tick to qualify it. Reset release adds two edges before any register moves. The bench drives inputs on falling edges and keeps a behavioural model that steps on each rising edge with those latencies. It compares every output at the following falling edge, so each result is checked in the cycle it becomes due. Separate counts check the settling length in ticks, and that outputs stay frozen after state 3 is reached.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  localparam logic [1:0] S2_LOW  = 2'b00;
  localparam logic [1:0] S2_MID  = 2'b01;
  localparam logic [1:0] S2_HIGH = 2'b10;

  typedef struct packed {
    logic       s1;
    logic [1:0] s2;
    logic       mult;
  } straps_t;

  // Illegal three-level code falls back to the middle level
  function automatic logic [1:0] s2_legal(input logic [1:0] code);
    return (code == 2'b11) ? S2_MID : code;
  endfunction
endpackage

// File: rtl/pgseq_rst_sync.sv
module pgseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pgseq_strobe_qual.sv
module pgseq_strobe_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pg_n,
  output logic qualified
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   low_seen_q;
  logic                   low_seen_d;
  logic                   pg_low;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pg_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pg_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    low_seen_d = low_seen_q;
    if (tick) low_seen_d = pg_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_seen_q <= 1'b0;
    else        low_seen_q <= low_seen_d;
  end

  assign qualified = tick & pg_low & low_seen_q;
endmodule

// File: rtl/pgseq_delay.sv
module pgseq_delay #(
  parameter int DELAY_TICKS = 3580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic done
);
  localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active)   cnt_d = '0;
    else if (tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = active & tick & (cnt_q == LAST);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> (!active || $stable(cnt_q)));
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top #(
  parameter int DELAY_TICKS = 3580,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       pg_n,
  input  logic       strap_s1,
  input  logic [1:0] strap_s2,
  input  logic       strap_mult,
  output logic       lat_s1,
  output logic [1:0] lat_s2,
  output logic       lat_mult,
  output logic       vco_en,
  output logic       out_en,
  output logic [1:0] seq_state
);
  import pgseq_pkg::*;

  logic       irst_n;
  logic       qual;
  logic       settle_done;
  seq_state_e state_q, state_d;
  straps_t    straps_q, straps_d;

  pgseq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(irst_n));

  pgseq_strobe_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst_n(irst_n), .tick(ref_tick), .pg_n(pg_n),
    .qualified(qual));

  pgseq_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
    .clk(clk), .rst_n(irst_n), .tick(ref_tick),
    .active(state_q == ST_SETTLE), .done(settle_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (ref_tick)    state_d = ST_WAIT;
      ST_WAIT:   if (qual)        state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_comb begin
    straps_d = straps_q;
    if (settle_done) begin
      straps_d.s1   = strap_s1;
      straps_d.s2   = s2_legal(strap_s2);
      straps_d.mult = strap_mult;
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      state_q  <= ST_OFF;
      straps_q <= '0;
    end else begin
      state_q  <= state_d;
      straps_q <= straps_d;
    end
  end

  assign seq_state = state_q;
  assign vco_en    = (state_q != ST_OFF);
  assign out_en    = (state_q == ST_RUN);
  assign lat_s1    = straps_q.s1;
  assign lat_s2    = straps_q.s2;
  assign lat_mult  = straps_q.mult;

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_RUN) |=> (state_q == ST_RUN));

  // R7
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_RUN) |=> $stable(straps_q));

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (!irst_n)
    !ref_tick |=> $stable(state_q));

  // R2
  off_exit_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_OFF && ref_tick) |=> (state_q == ST_WAIT));

  // R6
  s2_legal_chk: assert property (@(posedge clk) disable iff (!irst_n)
    straps_q.s2 != 2'b11);

  // R3
  wait_latch_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_WAIT) |=> $stable(straps_q));
endmodule

// File: tb/pgseq_top_tb.sv
`timescale 1ns/1ps
module pgseq_top_tb;
  localparam int D = 3580;

  logic clk = 1'b0;
  logic rst_n, ref_tick, pg_n, strap_s1, strap_mult;
  logic [1:0] strap_s2;
  logic lat_s1, lat_mult, vco_en, out_en;
  logic [1:0] lat_s2, seq_state;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit no_ticks = 0;
  bit finished = 0;
  int settle_ticks = 0;

  always #2.5 clk = ~clk;

  pgseq_top #(.DELAY_TICKS(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pg_n(pg_n),
    .strap_s1(strap_s1), .strap_s2(strap_s2), .strap_mult(strap_mult),
    .lat_s1(lat_s1), .lat_s2(lat_s2), .lat_mult(lat_mult),
    .vco_en(vco_en), .out_en(out_en), .seq_state(seq_state));

  // Behavioural reference model
  int m_rc = 0;
  int m_st = 0;
  int m_cnt = 0;
  bit m_low = 0;
  bit m_s1 = 0, m_mult = 0;
  bit [1:0] m_s2 = 0;
  bit pgq[$] = '{1'b1, 1'b1};

  task automatic model_clear();
    m_st = 0; m_cnt = 0; m_low = 0; m_s1 = 0; m_s2 = 0; m_mult = 0;
    pgq = '{1'b1, 1'b1};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rc = 0;
      model_clear();
    end else if (m_rc < 2) begin
      model_clear();
      m_rc++;
    end else begin
      bit old_sb, qual;
      old_sb = pgq[1];
      qual = ref_tick && !old_sb && m_low;
      if (ref_tick) m_low = !old_sb;
      case (m_st)
        0: if (ref_tick) m_st = 1;
        1: if (qual) begin m_st = 2; m_cnt = 0; end
        2: if (ref_tick) begin
             if (m_cnt == D - 1) begin
               m_st = 3;
               m_s1 = strap_s1;
               m_s2 = (strap_s2 == 2'b11) ? 2'b01 : strap_s2;
               m_mult = strap_mult;
             end else m_cnt++;
           end
        default: m_st = 3;
      endcase
      pgq.push_front(pg_n);
      void'(pgq.pop_back());
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk(seq_state == m_st[1:0], "R2 R4 R5 R8 state", seq_state, m_st);
    chk(vco_en == (m_st != 0), "R9 vco_en", vco_en, m_st != 0);
    chk(out_en == (m_st == 3), "R9 out_en", out_en, m_st == 3);
    chk({lat_s1, lat_s2, lat_mult} == {m_s1, m_s2, m_mult},
        "R3 R6 R7 straps", {lat_s1, lat_s2, lat_mult}, {m_s1, m_s2, m_mult});
  endtask

  task automatic run_clk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      cyc++;
      ref_tick = !no_ticks && ((cyc % 3 == 0) || (cyc % 7 == 0));
      if (ref_tick && seq_state == 2'd2) settle_ticks++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(seq_state == 0 && !vco_en && !out_en, "R1 state", seq_state, 0);
    chk({lat_s1, lat_s2, lat_mult} == 0, "R1 straps", {lat_s1, lat_s2, lat_mult}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_to_out(input int limit);
    for (int i = 0; i < limit && !out_en; i++) run_clk(1);
  endtask

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; pg_n = 1'b1;
    strap_s1 = 1'b0; strap_s2 = 2'b00; strap_mult = 1'b0;
    do_reset();
    run_clk(12);
    // R2: first tick leaves the off state
    chk(seq_state == 2'd1 && vco_en, "R2", seq_state, 1);

    // R3: straps driven while the strobe is high are not taken
    strap_s1 = 1'b1; strap_s2 = 2'b10; strap_mult = 1'b1;
    run_clk(120);
    chk(seq_state == 2'd1, "R3 state", seq_state, 1);
    chk({lat_s1, lat_s2, lat_mult} == 0, "R3 straps", {lat_s1, lat_s2, lat_mult}, 0);

    // R4: single-clock low pulse reaches at most one tick
    pg_n = 1'b0; run_clk(1); pg_n = 1'b1;
    run_clk(20);
    chk(seq_state == 2'd1, "R4 glitch", seq_state, 1);

    // R8: with no ticks, a held-low strobe cannot advance the state
    no_ticks = 1'b1; pg_n = 1'b0;
    run_clk(40);
    chk(seq_state == 2'd1, "R8 no tick", seq_state, 1);
    no_ticks = 1'b0;

    // R6: illegal S2 code latched as mid
    strap_s1 = 1'b1; strap_s2 = 2'b11; strap_mult = 1'b1;
    settle_ticks = 0;
    run_to_out(4 * D + 100);
    // R5: settling lasted exactly D ticks
    chk(out_en == 1'b1, "R5 reached", out_en, 1);
    chk(settle_ticks == D, "R5 length", settle_ticks, D);
    chk(lat_s2 == 2'b01 && lat_s1 && lat_mult, "R6 mid", lat_s2, 1);

    // R7: later strobe and strap activity ignored
    pg_n = 1'b1; strap_s1 = 1'b0; strap_s2 = 2'b00; strap_mult = 1'b0;
    run_clk(200);
    pg_n = 1'b0; run_clk(50); pg_n = 1'b1; run_clk(50);
    chk(seq_state == 2'd3 && out_en, "R7 state", seq_state, 3);
    chk({lat_s1, lat_s2, lat_mult} == 4'b1011, "R7 straps",
        {lat_s1, lat_s2, lat_mult}, 4'b1011);

    // R1: reset mid-run, then second run with high S2
    do_reset();
    strap_s1 = 1'b0; strap_s2 = 2'b10; strap_mult = 1'b1;
    pg_n = 1'b0;
    run_clk(30);
    // R8: ticks withheld during settling freeze the sequence
    no_ticks = 1'b1;
    run_clk(60);
    chk(seq_state == 2'd2, "R8 settle hold", seq_state, 2);
    no_ticks = 1'b0;
    run_to_out(4 * D + 100);
    chk(out_en == 1'b1, "R5 second run", out_en, 1);
    chk(lat_s2 == 2'b10 && !lat_s1 && lat_mult, "R6 high", lat_s2, 2);
    run_clk(20);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(995000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule